// File: doc/BRIEF.md
# Split Two's-Complement Exact Accumulator

This block sums a stream of exact floating-point products without rounding. Each product arrives as a sign, an unnormalised exponent and a mantissa. The sum is held in one wide fixed-point register that spans the whole range a product can reach. The register is split into `N` words of `b = 2^K` bits, and each word has its own small adder.

A shared front end works on each product. It shifts the mantissa inside a word by the low exponent bits. If the product is negative, it forms the two's complement over the full shifted width. It then rotates the `S` resulting words onto `S` bus lanes, so every word adder listens to one fixed lane. A word whose address lies inside the product's span adds its lane. When the product is negative, every word above the span adds all-ones, which extends the sign. Each word also adds the carry that the word below it registered one cycle earlier. Carries therefore climb one word per cycle, and the block takes one product every cycle.

A flush request starts `N` cycles with no input, which settle every pending carry. After them, `done` rises and `acc` holds the exact sum in two's complement.

A controller runs the sequence with three states:
- `ST_RUN`: products are accepted.
- `ST_FLUSH`: `N` cycles while carries settle.
- `ST_DONE`: the result is ready.

Its transitions are:
- RUN->FLUSH on a flush request.
- FLUSH->FLUSH while the cycle count is below `N-1`.
- FLUSH->DONE on the last flush cycle.
- DONE->RUN on a valid input.
- DONE->FLUSH on a flush request.
- Any state->RUN on clear.

Top module: `xacc_top`

## Requirements
- R1: After a flush completes, `acc` equals the sum of every accepted term `(-1)^sign * mant * 2^exp`, taken modulo `2^(N*b)` in two's complement.
- R2: The upper `WE-K` exponent bits choose the lowest target word and the low `K` bits choose the shift inside that word. Any bits of a term at or above weight `2^(N*b)` are dropped.
- R3: A negative term is subtracted exactly across all `N` words, including the words above its span. For example, a single negative term leaves `2^(N*b)` minus its magnitude.
- R4: A term with sign 1 and a zero mantissa adds nothing.
- R5: A product presented on every consecutive cycle is accepted on every cycle, and all of them are counted.
- R6: `done` goes high exactly `N` clock edges after the edge that samples `flush`, and not earlier.
- R7: While a flush is in progress, `in_valid` has no effect on the result.
- R8: `done` stays high until clear or a valid input. A valid input in the done state is accepted and drops `done` on the next edge.
- R9: After reset or a `clear` pulse, `acc` is zero and `done` is low.
- R10: Whenever `done` is high, no word holds a pending carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous zeroing of words, carries and state |
| in_valid | input | 1 | A product is present this cycle |
| in_sign | input | 1 | Product sign, 1 = negative |
| in_exp | input | WE | Product exponent (bit weight of the mantissa LSB) |
| in_mant | input | WM | Unnormalised product mantissa |
| flush | input | 1 | Request to settle carries and present the result |
| done | output | 1 | Result in `acc` is exact |
| acc | output | N*b | Accumulator words, word 0 in the low bits |

## Verification
Single terms are swept over every exponent with both signs. This shows whether the word address, the in-word shift, the lane rotation and the truncation at the top are right, and whether the all-ones sign extension reaches every word above the span. A long back-to-back stream of mixed-sign terms checks that carries spread across words over many cycles and stay in step with later inputs. A negative zero, inputs held during a flush, and valid or clear in the done state each test one edge of the control sequence against the arithmetic sum the bench computes.

// File: rtl/xacc_pkg.sv
package xacc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DONE  = 2'd2
    } xacc_state_e;

    // Number of words a mantissa of width wm covers after an in-word shift of up to b-1.
    function automatic int span_words(input int wm, input int b);
        return (wm - 1 + b + b - 1) / b;
    endfunction

endpackage

// File: rtl/xacc_ctrl.sv
module xacc_ctrl
    import xacc_pkg::*;
#(
    parameter int N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic in_valid,
    input  logic flush,
    output logic take,
    output logic done
);
    localparam int CW = $clog2(N + 1);

    xacc_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (clear) begin
            st_d  = ST_RUN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (flush) begin
                        st_d  = ST_FLUSH;
                        cnt_d = '0;
                    end
                end
                ST_FLUSH: begin
                    if (cnt_q == CW'(N - 1)) begin
                        st_d  = ST_DONE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (flush) begin
                        st_d  = ST_FLUSH;
                        cnt_d = '0;
                    end else if (in_valid) begin
                        st_d = ST_RUN;
                    end
                end
                default: begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        take = 1'b0;
        done = 1'b0;
        unique case (st_q)
            ST_RUN:   take = in_valid && !clear;
            ST_FLUSH: take = 1'b0;
            ST_DONE: begin
                take = in_valid && !clear;
                done = 1'b1;
            end
            default: take = 1'b0;
        endcase
    end

    // R7: nothing is taken while carries settle
    a_r7_no_take_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FLUSH) |-> !take);

    // R6: done only appears after the last flush cycle
    a_r6_done_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(st_q) == ST_FLUSH && $past(cnt_q) == CW'(N - 1)));

    // R8: done holds while nothing disturbs it
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !in_valid && !clear && !flush) |=> done);

endmodule

// File: rtl/xacc_align.sv
module xacc_align
    import xacc_pkg::*;
#(
    parameter int WE = 6,
    parameter int WM = 22,
    parameter int K  = 4
) (
    input  logic                          in_sign,
    input  logic [WE-1:0]                 in_exp,
    input  logic [WM-1:0]                 in_mant,
    output logic [WE-K-1:0]               base,
    output logic                          neg,
    output logic [span_words(WM, 1<<K)*(1<<K)-1:0] lanes
);
    localparam int B  = 1 << K;
    localparam int S  = span_words(WM, B);
    localparam int SB = S * B;

    logic [SB-1:0] shifted;
    logic [SB-1:0] twos;

    always_comb begin
        base    = in_exp[WE-1:K];
        neg     = in_sign && (|in_mant);
        shifted = SB'(in_mant) << in_exp[K-1:0];
        twos    = neg ? (~shifted + SB'(1)) : shifted;
    end

    // word j of the span goes to lane (base + j) mod S
    always_comb begin
        lanes = '0;
        for (int l = 0; l < S; l++) begin
            int j;
            j = (l + S - (int'(base) % S)) % S;
            lanes[l*B +: B] = twos[j*B +: B];
        end
    end

    // R3: a negated nonzero term always has its top span bit set
    always_comb begin
        if (neg) a_r3_neg_top: assert (twos[SB-1] == 1'b1);
    end

endmodule

// File: rtl/xacc_word.sv
module xacc_word
    import xacc_pkg::*;
#(
    parameter int K       = 4,
    parameter int AW      = 2,
    parameter int S       = 3,
    parameter int IDX     = 0,
    parameter bit TOPMOST = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            take,
    input  logic [AW-1:0]   base,
    input  logic            neg,
    input  logic [(1<<K)-1:0] lane,
    input  logic            cin,
    output logic [(1<<K)-1:0] word,
    output logic            cout
);
    localparam int B = 1 << K;

    logic [B-1:0] word_q;
    logic         cy_q;
    logic [B-1:0] addend;
    logic [B:0]   sum;

    always_comb begin
        int lo;
        int hi;
        lo = int'(base);
        hi = lo + S - 1;
        if (take && IDX >= lo && IDX <= hi)
            addend = lane;
        else if (take && neg && IDX > hi)
            addend = '1;
        else
            addend = '0;
        sum = {1'b0, word_q} + {1'b0, addend} + (B+1)'(cin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cy_q   <= 1'b0;
        end else if (clear) begin
            word_q <= '0;
            cy_q   <= 1'b0;
        end else begin
            word_q <= sum[B-1:0];
            cy_q   <= sum[B];
        end
    end

    assign word = word_q;
    assign cout = TOPMOST ? 1'b0 : cy_q;

    // R9: clear leaves the word empty
    a_r9_clear_word: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word == '0 && cout == 1'b0));

endmodule

// File: rtl/xacc_top.sv
module xacc_top
    import xacc_pkg::*;
#(
    parameter int WE = 6,
    parameter int WM = 22,
    parameter int K  = 4,
    parameter int N  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [WE-1:0]     in_exp,
    input  logic [WM-1:0]     in_mant,
    input  logic              flush,
    output logic              done,
    output logic [N*(1<<K)-1:0] acc
);
    localparam int B  = 1 << K;
    localparam int S  = span_words(WM, B);
    localparam int AW = WE - K;

    logic            take;
    logic [AW-1:0]   base;
    logic            neg;
    logic [S*B-1:0]  lanes;
    logic [N-1:0]    cy;

    xacc_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .in_valid (in_valid),
        .flush    (flush),
        .take     (take),
        .done     (done)
    );

    xacc_align #(.WE(WE), .WM(WM), .K(K)) u_align (
        .in_sign (in_sign),
        .in_exp  (in_exp),
        .in_mant (in_mant),
        .base    (base),
        .neg     (neg),
        .lanes   (lanes)
    );

    for (genvar i = 0; i < N; i++) begin : g_word
        logic cin_w;
        if (i == 0) begin : g_lo
            assign cin_w = 1'b0;
        end else begin : g_hi
            assign cin_w = cy[i-1];
        end
        xacc_word #(
            .K(K), .AW(AW), .S(S), .IDX(i), .TOPMOST(i == N - 1)
        ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .take  (take),
            .base  (base),
            .neg   (neg),
            .lane  (lanes[(i % S)*B +: B]),
            .cin   (cin_w),
            .word  (acc[i*B +: B]),
            .cout  (cy[i])
        );
    end

    // R10: carries have all landed when done is reported
    a_r10_settled: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cy == '0));

endmodule

// File: tb/sim_xacc_top.sv
`timescale 1ns/1ps
module sim_xacc_top;
    localparam int WE = 6;
    localparam int WM = 22;
    localparam int K  = 4;
    localparam int N  = 5;
    localparam int NB = N * (1 << K);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sign = 1'b0;
    logic [WE-1:0] in_exp = '0;
    logic [WM-1:0] in_mant = '0;
    logic          flush = 1'b0;
    logic          done;
    logic [NB-1:0] acc;

    int checks = 0;
    int errors = 0;
    logic [NB-1:0] model = '0;
    logic [31:0]   seed = 32'h1234_5678;

    always #10 clk = ~clk;

    xacc_top #(.WE(WE), .WM(WM), .K(K), .N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .flush(flush), .done(done), .acc(acc)
    );

    function automatic logic [NB-1:0] term(input logic s, input logic [WE-1:0] e,
                                           input logic [WM-1:0] m);
        logic [127:0]  x;
        logic [NB-1:0] t;
        x = 128'(m) << e;
        t = x[NB-1:0];
        return s ? (~t + NB'(1)) : t;
    endfunction

    task automatic chk(input string req, input logic [NB-1:0] got, input logic [NB-1:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, want);
        end
    endtask

    task automatic chk1(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, want);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic push(input logic s, input logic [WE-1:0] e, input logic [WM-1:0] m);
        in_valid = 1'b1; in_sign = s; in_exp = e; in_mant = m;
        model = model + term(s, e, m);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model = '0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        repeat (N) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R9: reset state
        chk("R9 reset acc", acc, '0);
        chk1("R9 reset done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: every exponent, both signs, single term
        for (int e = 0; e < (1 << WE); e++) begin
            for (int s = 0; s < 2; s++) begin
                logic [WM-1:0] m;
                m = 22'h2AB5C3 ^ (WM'(e) << 9) ^ WM'(s * 22'h155);
                do_clear();
                push(s[0], e[WE-1:0], m);
                do_flush();
                chk(s ? "R3 single negative" : "R2 single positive", acc, model);
            end
        end

        // R4: negative zero adds nothing
        do_clear();
        push(1'b0, 6'd7, 22'h00_0001);
        push(1'b1, 6'd20, 22'h0);
        do_flush();
        chk("R4 negative zero", acc, term(1'b0, 6'd7, 22'h1));

        // R5 R1: long back-to-back stream of mixed terms
        do_clear();
        for (int i = 0; i < 400; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            in_valid = 1'b1;
            in_sign  = seed[31];
            in_exp   = seed[21:16];
            in_mant  = {seed[15:0], seed[29:24]};
            model = model + term(in_sign, in_exp, in_mant);
            @(negedge clk);
        end
        in_valid = 1'b0;
        do_flush();
        chk("R5 stream sum", acc, model);

        // R1: carry ripple through every word, all-ones then +1
        do_clear();
        push(1'b1, 6'd0, 22'h1);
        push(1'b0, 6'd0, 22'h1);
        push(1'b1, 6'd0, 22'h1);
        do_flush();
        chk("R1 ripple to all-ones", acc, {NB{1'b1}});
        push(1'b0, 6'd0, 22'h1);
        do_flush();
        chk("R1 ripple wraps to zero", acc, '0);

        // R6: done timing
        do_clear();
        push(1'b0, 6'd12, 22'h3F_FFFF);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        repeat (N - 1) @(negedge clk);
        chk1("R6 done not early", done, 1'b0);
        @(negedge clk);
        chk1("R6 done on time", done, 1'b1);
        chk("R6 result", acc, model);

        // R7: inputs during flush are ignored
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b1; in_sign = 1'b1; in_exp = 6'd30; in_mant = 22'h12345;
        repeat (N) @(negedge clk);
        in_valid = 1'b0;
        chk1("R7 done after ignored", done, 1'b1);
        chk("R7 inputs ignored", acc, model);

        // R8: done holds, then valid drops it and is accepted
        repeat (3) @(negedge clk);
        chk1("R8 done holds", done, 1'b1);
        push(1'b1, 6'd33, 22'h2_0F0F);
        chk1("R8 valid drops done", done, 1'b0);
        do_flush();
        chk("R8 valid accepted in done", acc, model);

        // R9: clear zeroes
        do_clear();
        chk("R9 clear acc", acc, '0);
        chk1("R9 clear done", done, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule